// File: doc/BRIEF.md
# Cacheability Qualifier and Line Fill Sequencer

This block sits between a processor core's read traffic and a small on-chip cache built from 4-byte lines. When the core announces a read, the block decides whether the read may be cached. The decision looks at the kind of cycle, at four non-cacheable address windows, and at the outcome of each bus cycle. That outcome is given by an active-low cache-enable pin, which a configuration bit may switch off. For a cacheable read, the block follows the 16-bit bus cycles that return the data. For each one it produces byte write strobes and data for the cache array, per-byte valid set and clear masks, and a pulse when the fill finishes.

Instruction fetches always fill the whole line in two bus cycles: the low half first, then the high half. The pin must be seen asserted on both cycles. If it is not seen on the second cycle, the half already written is withdrawn. Data reads run only the half-line cycles that the operand touches, so a line may be partly valid. Every cycle that is filled writes both bytes of its half, whatever the byte enables say. Tag storage, replacement and write handling live elsewhere.

Top module: `linefill_qualifier`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, cacheWrStrb, validSet, validClr and fillDone are all zero.
- R2: Cycle kind codes on reqType are 0 for an instruction fetch, 1 for a memory data read, 2 for an I/O read, 3 for a locked read, 4 for a system-management-space read and 5 for an interrupt acknowledge. Only codes 0 and 1 can ever produce a cache write.
- R3: There are four windows, each with a base and a size code k. For k nonzero, a window covers the 2^k bytes whose address matches the base above bit k-1. Size code 0 disables the window. A read whose address falls in an enabled window never writes the cache, whatever the pin does.
- R4: A cacheable instruction fetch takes two bus cycles. The low half-line (strobe 4'b0011) is filled first and the high half-line (strobe 4'b1100) second. Each write appears in the cycle after the clock edge where busReady was sampled high.
- R5: Every filled bus cycle writes both bytes of its half-line and ignores the byte enables. cacheWrData carries the bus word in both halves, {rdData, rdData}.
- R6: If an instruction fetch sees the pin deasserted on its second cycle, that cycle writes nothing and validClr is 4'b0011. If the fetch sees the pin deasserted on its first cycle, neither of its cycles writes.
- R7: With cfgKenEn low, cacheEnN is ignored and is treated as asserted. With cfgKenEn high, cacheEnN high at the ready edge blocks the write of that bus cycle.
- R8: fillDone pulses together with the outputs of the last bus cycle of a cacheable read, only when the pin was seen asserted on every cycle of that read.
- R9: For a data read, reqBe bits 1:0 select the low half-line and bits 3:2 the high half-line. Only the selected halves are run, low before high. A data read with reqBe zero is not cached. In a data read, each cycle is filled or skipped on its own pin sample.
- R10: validSet equals cacheWrStrb on every write. cacheLineAddr holds reqAddr[23:2] of the read being filled.
- R11: A request arriving while a fill is in progress is ignored, and so is busReady while no fill is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgKenEn | input | 1 | Enables use of cacheEnN |
| rgnBase | input | 4x24 | Base address of each non-cacheable window |
| rgnSize | input | 4x5 | Size code of each window, 0 disables it |
| reqValid | input | 1 | Read request announce pulse |
| reqType | input | 3 | Cycle kind code |
| reqAddr | input | 24 | Byte address of the read |
| reqBe | input | 4 | Operand byte enables within the line |
| cacheEnN | input | 1 | Active-low cache-enable pin, sampled with busReady |
| busReady | input | 1 | Ends the current bus cycle |
| rdData | input | 16 | Bus read data |
| cacheWrStrb | output | 4 | Cache array byte write strobes |
| cacheWrData | output | 32 | Cache array write data |
| cacheLineAddr | output | 22 | Line address of the fill |
| validSet | output | 4 | Per-byte valid bits to set |
| validClr | output | 4 | Per-byte valid bits to clear |
| fillDone | output | 1 | Fill completed pulse |

## Verification
The assertions check, on every cycle, several rules that do not depend on what was requested. A write always covers exactly one half-line. A write, a clear or a done pulse only follows a ready edge. A clear never coincides with a set. When the pin is in use, no write follows a cycle where the pin was deasserted. The bench sweeps every cycle kind, byte-enable pattern, pin sample pair and enable setting over addresses inside and just outside each window. Only those scenarios can show that the cycle kind and the window lookup block a fill, that halves are ordered and selected correctly, and that an aborted fetch withdraws the low half.

// File: rtl/lfq_pkg.sv
package lfq_pkg;
  typedef enum logic [2:0] {
    CYC_CODE   = 3'd0,
    CYC_MEMRD  = 3'd1,
    CYC_IORD   = 3'd2,
    CYC_LOCKRD = 3'd3,
    CYC_SMMRD  = 3'd4,
    CYC_INTA   = 3'd5
  } cyc_kind_e;

  typedef struct packed {
    logic loadReq;
    logic writeHalf;
    logic halfSel;
    logic clearLow;
    logic done;
  } lfq_strobe_t;
endpackage

// File: rtl/lfq_region_match.sv
module lfq_region_match #(
  parameter int ADDR_W  = 24,
  parameter int NUM_RGN = 4,
  parameter int SZ_W    = 5
) (
  input  logic [ADDR_W-1:0]                addr,
  input  logic [NUM_RGN-1:0][ADDR_W-1:0]   rgnBase,
  input  logic [NUM_RGN-1:0][SZ_W-1:0]     rgnSize,
  output logic                             hit
);
  logic [NUM_RGN-1:0] hitVec;

  for (genvar g = 0; g < NUM_RGN; g++) begin : g_rgn
    logic [ADDR_W-1:0] diff;
    assign diff      = addr ^ rgnBase[g];
    assign hitVec[g] = (rgnSize[g] != '0) && ((diff >> rgnSize[g]) == '0);
  end

  assign hit = |hitVec;
endmodule

// File: rtl/lfq_ctrl.sv
module lfq_ctrl
  import lfq_pkg::*;
#(
  parameter int BE_W = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            cfgKenEn,
  input  logic            reqValid,
  input  logic [2:0]      reqType,
  input  logic [BE_W-1:0] reqBe,
  input  logic            rgnHit,
  input  logic            cacheEnN,
  input  logic            busReady,
  output lfq_strobe_t     strobe
);
  localparam int HALF_BE = BE_W / 2;

  logic       active, isCode, okAll;
  logic [1:0] pend, pendNext;
  logic       kenOk, kindOk, acceptCache, halfNow, lastCyc, step;
  logic       reqCode;

  assign reqCode     = (reqType == CYC_CODE);
  assign kindOk      = reqCode || (reqType == CYC_MEMRD);
  assign kenOk       = !cfgKenEn || !cacheEnN;
  assign acceptCache = reqValid && !active && kindOk && !rgnHit &&
                       (reqCode || (reqBe != '0));

  assign halfNow  = !pend[0];
  assign pendNext = pend & (halfNow ? 2'b01 : 2'b10);
  assign lastCyc  = (pendNext == 2'b00);
  assign step     = active && busReady;

  always_comb begin
    strobe           = '0;
    strobe.loadReq   = acceptCache;
    strobe.halfSel   = halfNow;
    strobe.writeHalf = step && kenOk && (!isCode || okAll);
    strobe.clearLow  = step && isCode && halfNow && okAll && !kenOk;
    strobe.done      = step && lastCyc && okAll && kenOk;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active <= 1'b0;
      isCode <= 1'b0;
      okAll  <= 1'b0;
      pend   <= 2'b00;
    end else if (acceptCache) begin
      active <= 1'b1;
      isCode <= reqCode;
      okAll  <= 1'b1;
      pend   <= reqCode ? 2'b11
                        : {|reqBe[BE_W-1:HALF_BE], |reqBe[HALF_BE-1:0]};
    end else if (step) begin
      pend  <= pendNext;
      okAll <= okAll & kenOk;
      if (lastCyc) active <= 1'b0;
    end
  end
endmodule

// File: rtl/lfq_dpath.sv
module lfq_dpath
  import lfq_pkg::*;
#(
  parameter int ADDR_W  = 24,
  parameter int NUM_RGN = 4,
  parameter int SZ_W    = 5,
  parameter int BUS_W   = 16
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  lfq_strobe_t                    strobe,
  input  logic [ADDR_W-1:0]              reqAddr,
  input  logic [NUM_RGN-1:0][ADDR_W-1:0] rgnBase,
  input  logic [NUM_RGN-1:0][SZ_W-1:0]   rgnSize,
  input  logic [BUS_W-1:0]               rdData,
  output logic                           rgnHit,
  output logic [3:0]                     cacheWrStrb,
  output logic [2*BUS_W-1:0]             cacheWrData,
  output logic [ADDR_W-3:0]              cacheLineAddr,
  output logic [3:0]                     validSet,
  output logic [3:0]                     validClr,
  output logic                           fillDone
);
  localparam logic [3:0] LOW_HALF  = 4'b0011;
  localparam logic [3:0] HIGH_HALF = 4'b1100;

  logic [3:0] halfMask;

  lfq_region_match #(.ADDR_W(ADDR_W), .NUM_RGN(NUM_RGN), .SZ_W(SZ_W)) u_match (
    .addr    (reqAddr),
    .rgnBase (rgnBase),
    .rgnSize (rgnSize),
    .hit     (rgnHit)
  );

  assign halfMask = strobe.halfSel ? HIGH_HALF : LOW_HALF;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cacheWrStrb   <= '0;
      cacheWrData   <= '0;
      cacheLineAddr <= '0;
      validSet      <= '0;
      validClr      <= '0;
      fillDone      <= 1'b0;
    end else begin
      if (strobe.loadReq) cacheLineAddr <= reqAddr[ADDR_W-1:2];
      cacheWrStrb <= strobe.writeHalf ? halfMask : 4'b0000;
      validSet    <= strobe.writeHalf ? halfMask : 4'b0000;
      validClr    <= strobe.clearLow ? LOW_HALF : 4'b0000;
      fillDone    <= strobe.done;
      if (strobe.writeHalf) cacheWrData <= {rdData, rdData};
    end
  end
endmodule

// File: rtl/linefill_qualifier.sv
module linefill_qualifier
  import lfq_pkg::*;
#(
  parameter int ADDR_W  = 24,
  parameter int NUM_RGN = 4,
  parameter int BUS_W   = 16,
  parameter int SZ_W    = $clog2(ADDR_W + 1)
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           cfgKenEn,
  input  logic [NUM_RGN-1:0][ADDR_W-1:0] rgnBase,
  input  logic [NUM_RGN-1:0][SZ_W-1:0]   rgnSize,
  input  logic                           reqValid,
  input  logic [2:0]                     reqType,
  input  logic [ADDR_W-1:0]              reqAddr,
  input  logic [3:0]                     reqBe,
  input  logic                           cacheEnN,
  input  logic                           busReady,
  input  logic [BUS_W-1:0]               rdData,
  output logic [3:0]                     cacheWrStrb,
  output logic [2*BUS_W-1:0]             cacheWrData,
  output logic [ADDR_W-3:0]              cacheLineAddr,
  output logic [3:0]                     validSet,
  output logic [3:0]                     validClr,
  output logic                           fillDone
);
  lfq_strobe_t strobe;
  logic        rgnHit;

  lfq_ctrl #(.BE_W(4)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cfgKenEn (cfgKenEn),
    .reqValid (reqValid),
    .reqType  (reqType),
    .reqBe    (reqBe),
    .rgnHit   (rgnHit),
    .cacheEnN (cacheEnN),
    .busReady (busReady),
    .strobe   (strobe)
  );

  lfq_dpath #(.ADDR_W(ADDR_W), .NUM_RGN(NUM_RGN), .SZ_W(SZ_W), .BUS_W(BUS_W)) u_dpath (
    .clk           (clk),
    .rstN          (rstN),
    .strobe        (strobe),
    .reqAddr       (reqAddr),
    .rgnBase       (rgnBase),
    .rgnSize       (rgnSize),
    .rdData        (rdData),
    .rgnHit        (rgnHit),
    .cacheWrStrb   (cacheWrStrb),
    .cacheWrData   (cacheWrData),
    .cacheLineAddr (cacheLineAddr),
    .validSet      (validSet),
    .validClr      (validClr),
    .fillDone      (fillDone)
  );
endmodule

// File: rtl/linefill_qualifier_checker.sv
module linefill_qualifier_checker (
  input logic       clk,
  input logic       rstN,
  input logic       cfgKenEn,
  input logic       cacheEnN,
  input logic       busReady,
  input logic [3:0] cacheWrStrb,
  input logic [3:0] validSet,
  input logic [3:0] validClr,
  input logic       fillDone
);
  // R4, R5: a write always covers exactly one half-line
  p_one_half_r5: assert property (@(posedge clk) disable iff (!rstN)
    (cacheWrStrb == 4'b0000) || (cacheWrStrb == 4'b0011) || (cacheWrStrb == 4'b1100));

  // R4: a write only follows a ready edge
  p_write_after_ready_r4: assert property (@(posedge clk) disable iff (!rstN)
    (cacheWrStrb != 4'b0000) |-> $past(busReady));

  // R6: a withdrawal touches only the low half and never comes with a set
  p_clear_low_only_r6: assert property (@(posedge clk) disable iff (!rstN)
    (validClr != 4'b0000) |-> ((validClr == 4'b0011) && (validSet == 4'b0000) && $past(busReady)));

  // R7: with the pin in use, a deasserted sample blocks the write
  p_pin_gates_write_r7: assert property (@(posedge clk) disable iff (!rstN)
    (cacheWrStrb != 4'b0000) |-> (!$past(cfgKenEn) || !$past(cacheEnN)));

  // R8: completion only follows a ready edge and never comes with a withdrawal
  p_done_after_ready_r8: assert property (@(posedge clk) disable iff (!rstN)
    fillDone |-> ($past(busReady) && (validClr == 4'b0000)));
endmodule

bind linefill_qualifier linefill_qualifier_checker u_checker (
  .clk         (clk),
  .rstN        (rstN),
  .cfgKenEn    (cfgKenEn),
  .cacheEnN    (cacheEnN),
  .busReady    (busReady),
  .cacheWrStrb (cacheWrStrb),
  .validSet    (validSet),
  .validClr    (validClr),
  .fillDone    (fillDone)
);

// File: tb/linefill_qualifier_tb.sv
module linefill_qualifier_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgKenEn = 1'b0;
  logic [3:0][23:0] rgnBase;
  logic [3:0][4:0]  rgnSize;
  logic reqValid = 1'b0;
  logic [2:0] reqType = 3'd0;
  logic [23:0] reqAddr = '0;
  logic [3:0] reqBe = '0;
  logic cacheEnN = 1'b1;
  logic busReady = 1'b0;
  logic [15:0] rdData = '0;
  logic [3:0]  cacheWrStrb;
  logic [31:0] cacheWrData;
  logic [21:0] cacheLineAddr;
  logic [3:0]  validSet, validClr;
  logic        fillDone;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  linefill_qualifier u_dut (
    .clk(clk), .rstN(rstN), .cfgKenEn(cfgKenEn), .rgnBase(rgnBase), .rgnSize(rgnSize),
    .reqValid(reqValid), .reqType(reqType), .reqAddr(reqAddr), .reqBe(reqBe),
    .cacheEnN(cacheEnN), .busReady(busReady), .rdData(rdData),
    .cacheWrStrb(cacheWrStrb), .cacheWrData(cacheWrData), .cacheLineAddr(cacheLineAddr),
    .validSet(validSet), .validClr(validClr), .fillDone(fillDone)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic bit inWindow(input logic [23:0] a);
    bit h = 1'b0;
    for (int r = 0; r < 4; r++)
      if (rgnSize[r] != 0 && ((a >> rgnSize[r]) == (rgnBase[r] >> rgnSize[r]))) h = 1'b1;
    return h;
  endfunction

  function automatic logic [23:0] addrOf(input int i);
    case (i)
      0: return 24'h000104;
      1: return 24'h10ABCD;
      2: return 24'h110000;
      3: return 24'h00F7FE;
      4: return 24'h00EFFC;
      default: return 24'h9ABCDE;
    endcase
  endfunction

  task automatic runAcc(input logic [2:0] t, input logic [23:0] a, input logic [3:0] be,
                        input logic [1:0] kenN, input logic en, input int seed);
    logic [1:0] hs;
    bit cach, okAll, ok, wr, clr, done, last;
    int idx = 0;
    logic [15:0] d;
    hs = (t == 3'd0) ? 2'b11 : {|be[3:2], |be[1:0]};
    cach = (t <= 3'd1) && !inWindow(a) && (hs != 2'b00);
    if (hs == 2'b00) hs = 2'b01;
    @(negedge clk);
    reqValid = 1'b1; reqType = t; reqAddr = a; reqBe = be; cfgKenEn = en;
    @(negedge clk);
    reqValid = 1'b0;
    okAll = 1'b1;
    for (int h = 0; h < 2; h++) begin
      if (hs[h]) begin
        ok = !en || !kenN[idx];
        d = 16'(seed * 16'h3b1 + h * 16'h5a5a + 1);
        busReady = 1'b1; cacheEnN = kenN[idx]; rdData = d;
        @(negedge clk);
        busReady = 1'b0; cacheEnN = 1'b1;
        last = ((hs >> (h + 1)) == 2'b00);
        if (t == 3'd0) begin
          wr  = cach && okAll && ok;
          clr = cach && okAll && !ok && (h == 1);
        end else begin
          wr  = cach && ok;
          clr = 1'b0;
        end
        done = cach && last && okAll && ok;
        okAll = okAll && ok;
        idx++;
        check("R4 R2 R3 R7 R9 strobe", 64'(cacheWrStrb), wr ? (h == 1 ? 64'hC : 64'h3) : 64'h0);
        check("R10 validSet", 64'(validSet), wr ? (h == 1 ? 64'hC : 64'h3) : 64'h0);
        check("R6 validClr", 64'(validClr), clr ? 64'h3 : 64'h0);
        check("R8 fillDone", 64'(fillDone), 64'(done));
        if (wr) begin
          check("R5 data", 64'(cacheWrData), 64'({d, d}));
          check("R10 lineAddr", 64'(cacheLineAddr), 64'(a >> 2));
        end
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    rgnBase[0] = 24'h100000; rgnSize[0] = 5'd16;
    rgnBase[1] = 24'h000000; rgnSize[1] = 5'd0;
    rgnBase[2] = 24'h00F000; rgnSize[2] = 5'd12;
    rgnBase[3] = 24'h800000; rgnSize[3] = 5'd23;
    repeat (3) @(negedge clk);
    check("R1 reset strobe", 64'(cacheWrStrb), 64'h0);
    check("R1 reset valid", 64'({validSet, validClr}), 64'h0);
    check("R1 reset done", 64'(fillDone), 64'h0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 post-reset", 64'({cacheWrStrb, validSet, validClr, fillDone}), 64'h0);

    // R11: second request mid-fill is ignored
    @(negedge clk);
    reqValid = 1'b1; reqType = 3'd0; reqAddr = 24'h000240; reqBe = 4'h0; cfgKenEn = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    busReady = 1'b1; cacheEnN = 1'b0; rdData = 16'h1234;
    @(negedge clk);
    busReady = 1'b0; cacheEnN = 1'b1;
    check("R4 first half", 64'(cacheWrStrb), 64'h3);
    reqValid = 1'b1; reqType = 3'd1; reqAddr = 24'h000880; reqBe = 4'h1;
    @(negedge clk);
    reqValid = 1'b0;
    busReady = 1'b1; cacheEnN = 1'b0; rdData = 16'hABCD;
    @(negedge clk);
    busReady = 1'b0; cacheEnN = 1'b1;
    check("R11 high half kept", 64'(cacheWrStrb), 64'hC);
    check("R11 line kept", 64'(cacheLineAddr), 64'(24'h000240 >> 2));
    check("R11 done", 64'(fillDone), 64'h1);
    // R11: the ignored request left nothing behind
    busReady = 1'b1; cacheEnN = 1'b0;
    @(negedge clk);
    busReady = 1'b0; cacheEnN = 1'b1;
    check("R11 idle ready", 64'({cacheWrStrb, validSet, fillDone}), 64'h0);

    for (int t = 0; t < 6; t++)
      for (int ai = 0; ai < 6; ai++)
        for (int be = 0; be < 16; be++)
          for (int k = 0; k < 4; k++)
            for (int en = 0; en < 2; en++)
              if (t != 0 || be == 15)
                runAcc(3'(t), addrOf(ai), 4'(be), 2'(k), 1'(en), t * 997 + ai * 131 + be * 7 + k + en);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule